// File: doc/BRIEF.md
# Dual-Period Carrier Pulse Counter

This block generates a carrier-style waveform on a single output whose high phase and low phase each last a separately programmed number of prescaled clock ticks. Two data registers hold the durations: one is loaded while the output is high, the other while it is low. Each time a phase count runs out, the output toggles and the counter reloads from the register for the new level. A prescaler divides the system clock by 1, 2, 4 or 8 to form the counting tick.

Software controls the block through a small address/strobe register port. From that port it can start and stop the counter and choose one-shot or repeating operation. It can also force the output level and pick which phase endings raise an interrupt. The interrupt output is a pending flag gated by an enable bit. Software reads the flag and clears it by writing a one to it. The block moves no data, so it has no stream interface: writes take effect at the clock edge of the strobe, and reads are combinational from the address.

Top module: `carrier_counter`

## Requirements
- R1: After reset the high-duration and low-duration registers read 0xFF, the control register reads 0x00, the output is low and the interrupt output is low.
- R2: Clock-select field code s (control bits 5:4) makes every prescaled tick last 2^s system clocks: 00 every clock, 01 every 2, 10 every 4, 11 every 8.
- R3: A phase programmed with value N lasts (N+1)*2^s system clocks, so N=0 still gives a phase one tick long. The high phase counts the high-duration register (address 1) and the low phase counts the low-duration register (address 2). When a phase ends the output toggles.
- R4: The run bit (control bit 0) written from 0 to 1 loads the counter for the current output level and starts counting. Clearing it freezes the output and the count.
- R5: With the mode bit (control bit 1) at 0 (one-shot), the run bit clears itself at the end of the second phase after a start. With the mode bit at 1 (repeating), the phases keep alternating until software clears the run bit.
- R6: Writing address 3 sets the output level to bit 0 of the written value, and address 3 reads that level back in bit 0.
- R7: The interrupt-time field (control bits 7:6) sets the pending flag when a low phase ends for code 00, when a high phase ends for code 01, and when either phase ends for code 10. Code 11 never sets it.
- R8: The interrupt output equals the pending flag (control bit 2) ANDed with the interrupt enable (control bit 3). The pending flag sets whatever the enable is.
- R9: Writing the control register with bit 2 at 1 clears the pending flag, and writing bit 2 at 0 leaves it unchanged. If the flag sets in the same cycle as a clearing write, the flag ends up set.
- R10: The data registers at addresses 1 and 2 read back exactly the value last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register address: 0 control, 1 high duration, 2 low duration, 3 output level |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr, combinational |
| wave_out | output | 1 | Carrier waveform output |
| irq | output | 1 | Interrupt request, pending AND enable |

## Verification
A wrong count or a reload from the wrong register shows up on wave_out at the very next toggle: that phase length differs from (N+1)*2^s. The bench therefore measures every phase to the exact clock. A stuck prescaler stretches every phase by a whole multiple of the tick period, so it is visible within one phase. Wrong pending logic shows in the control readback and on irq in the cycle after the phase ends. Random durations, dividers, levels and interrupt codes are mixed with directed cases: zero-length phases, the maximum count, and a clearing write that collides with a set.

// File: rtl/cc_pkg.sv
package cc_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] A_CTRL  = 2'd0;
  localparam logic [ADDR_W-1:0] A_HIGH  = 2'd1;
  localparam logic [ADDR_W-1:0] A_LOW   = 2'd2;
  localparam logic [ADDR_W-1:0] A_LEVEL = 2'd3;

  typedef enum logic [1:0] {
    IT_LOW  = 2'b00,
    IT_HIGH = 2'b01,
    IT_BOTH = 2'b10,
    IT_NONE = 2'b11
  } itime_e;

  typedef struct packed {
    itime_e     itime;
    logic [1:0] clk_sel;
    logic       irq_en;
    logic       pend;
    logic       mode;
    logic       run;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/cc_prescaler.sv
module cc_prescaler #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int PW = (1 << SEL_W) - 1;

  logic [PW-1:0] pre_q;
  logic [PW-1:0] limit;

  always_comb begin
    limit = PW'((32'd1 << sel) - 32'd1);
    tick  = run && (pre_q == limit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             pre_q <= '0;
    else if (!run || tick)  pre_q <= '0;
    else                    pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/cc_regs.sv
module cc_regs
  import cc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              set_pend,
  input  logic              core_done,
  input  logic              cur_level,
  output ctrl_t             ctrl_q,
  output logic [DATA_W-1:0] high_q,
  output logic [DATA_W-1:0] low_q,
  output logic              load,
  output logic              lvl_wr
);
  logic ctrl_wr;
  ctrl_t wr_ctrl;

  always_comb begin
    ctrl_wr = bus_wr && (bus_addr == A_CTRL);
    lvl_wr  = bus_wr && (bus_addr == A_LEVEL);
    wr_ctrl = ctrl_t'(bus_wdata[CTRL_W-1:0]);
    load    = ctrl_wr && wr_ctrl.run && !ctrl_q.run;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      high_q <= '1;
      low_q  <= '1;
    end else begin
      if (ctrl_wr) begin
        ctrl_q      <= wr_ctrl;
        ctrl_q.pend <= set_pend | (ctrl_q.pend & ~wr_ctrl.pend);
      end else begin
        if (set_pend)  ctrl_q.pend <= 1'b1;
        if (core_done) ctrl_q.run  <= 1'b0;
      end
      if (bus_wr && bus_addr == A_HIGH) high_q <= bus_wdata;
      if (bus_wr && bus_addr == A_LOW)  low_q  <= bus_wdata;
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      A_CTRL:  bus_rdata = DATA_W'(ctrl_q);
      A_HIGH:  bus_rdata = high_q;
      A_LOW:   bus_rdata = low_q;
      default: bus_rdata = DATA_W'(cur_level);
    endcase
  end
endmodule

// File: rtl/cc_phase_core.sv
module cc_phase_core
  import cc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              tick,
  input  logic              oneshot,
  input  itime_e            itime,
  input  logic [DATA_W-1:0] high_val,
  input  logic [DATA_W-1:0] low_val,
  input  logic              lvl_wr,
  input  logic              lvl_val,
  output logic              level,
  output logic              expire,
  output logic              set_pend,
  output logic              done
);
  logic [DATA_W-1:0] cnt_q;
  logic              half_q;
  logic              low_hit, high_hit;

  always_comb begin
    expire   = tick && (cnt_q == '0);
    low_hit  = (itime == IT_LOW)  || (itime == IT_BOTH);
    high_hit = (itime == IT_HIGH) || (itime == IT_BOTH);
    set_pend = expire && (level ? high_hit : low_hit);
    done     = expire && half_q && oneshot;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      half_q <= 1'b0;
      level  <= 1'b0;
    end else begin
      if (load) begin
        cnt_q  <= level ? high_val : low_val;
        half_q <= 1'b0;
      end else if (expire) begin
        cnt_q  <= level ? low_val : high_val;
        half_q <= ~half_q;
        level  <= ~level;
      end else if (tick) begin
        cnt_q  <= cnt_q - 1'b1;
      end
      if (lvl_wr) level <= lvl_val;
    end
  end
endmodule

// File: rtl/carrier_counter.sv
module carrier_counter
  import cc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              wave_out,
  output logic              irq
);
  localparam int SEL_W = $bits(ctrl_q.clk_sel);

  ctrl_t             ctrl_q;
  logic [DATA_W-1:0] high_q, low_q;
  logic              load, lvl_wr, tick_w, expire_w, set_pend, done_w, level;

  cc_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .set_pend(set_pend), .core_done(done_w), .cur_level(level),
    .ctrl_q(ctrl_q), .high_q(high_q), .low_q(low_q), .load(load), .lvl_wr(lvl_wr)
  );

  cc_prescaler #(.SEL_W(SEL_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(ctrl_q.run), .sel(ctrl_q.clk_sel), .tick(tick_w)
  );

  cc_phase_core #(.DATA_W(DATA_W)) u_core (
    .clk(clk), .rst_n(rst_n), .load(load), .tick(tick_w),
    .oneshot(!ctrl_q.mode), .itime(ctrl_q.itime),
    .high_val(high_q), .low_val(low_q),
    .lvl_wr(lvl_wr), .lvl_val(bus_wdata[0]),
    .level(level), .expire(expire_w), .set_pend(set_pend), .done(done_w)
  );

  assign wave_out = level;
  assign irq      = ctrl_q.pend & ctrl_q.irq_en;
endmodule

// File: rtl/cc_checker.sv
module cc_checker
  import cc_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] bus_addr,
  input logic       bus_wr,
  input logic       wave_out,
  input ctrl_t      ctrl_q,
  input logic       tick_w,
  input logic       expire_w,
  input logic       done_w
);
  logic lvl_write, ctrl_write;
  assign lvl_write  = bus_wr && bus_addr == A_LEVEL;
  assign ctrl_write = bus_wr && bus_addr == A_CTRL;

  AST_TOGGLE_ON_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_w && !lvl_write) |=> (wave_out != $past(wave_out))); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q.run && !lvl_write) |=> $stable(wave_out)); // R4
  AST_UNDIVIDED_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.run && ctrl_q.clk_sel == 2'b00) |-> tick_w); // R2
  AST_INVALID_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.itime == IT_NONE && !ctrl_q.pend && !ctrl_write) |=> !ctrl_q.pend); // R7
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_w && ctrl_q.itime == IT_BOTH) |=> ctrl_q.pend); // R9
  AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (done_w && !ctrl_write) |=> !ctrl_q.run); // R5
endmodule

bind carrier_counter cc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .wave_out(wave_out), .ctrl_q(ctrl_q), .tick_w(tick_w),
  .expire_w(expire_w), .done_w(done_w)
);

// File: tb/test_carrier_counter.sv
`timescale 1ns/1ps
module test_carrier_counter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       wave_out, irq;
  int checks = 0, fails = 0;
  bit finished = 1'b0;

  carrier_counter i_carrier_counter (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wave_out(wave_out), .irq(irq)
  );

  always #10 clk = ~clk;

  function automatic int exp_len(int n, int sel);
    return (n + 1) << sel;
  endfunction

  function automatic bit exp_pend_after(bit ended_level, int it);
    if (it == 2) return 1'b1;
    if (it == 3) return 1'b0;
    return ended_level ? (it == 1) : (it == 0);
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic measure(output int len);
    logic old;
    old = wave_out;
    len = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      len++;
      if (wave_out != old) break;
    end
  endtask

  task automatic run_case(int hi, int lo, int sel, int it, bit mode, bit lvl, bit ie);
    int len;
    logic [7:0] v;
    logic [7:0] cw;
    bit pexp;
    cw = {it[1:0], sel[1:0], ie, 1'b1, mode, 1'b1};
    wr(2'd1, hi[7:0]);
    wr(2'd2, lo[7:0]);
    wr(2'd3, {7'd0, lvl});
    wr(2'd0, cw);
    measure(len);
    check("R3 first phase length", len, exp_len(lvl ? hi : lo, sel));
    rd(2'd0, v);
    pexp = exp_pend_after(lvl, it);
    check("R7 pending after first phase", v[2], pexp);
    check("R8 irq after first phase", irq, pexp & ie);
    measure(len);
    check("R2 second phase length", len, exp_len(lvl ? lo : hi, sel));
    rd(2'd0, v);
    check("R7 pending after both phases", v[2], pexp | exp_pend_after(!lvl, it));
    check("R5 run bit after two phases", v[0], mode);
    if (mode) wr(2'd0, {cw[7:3], 1'b0, 1'b1, 1'b0});
    v[0] = wave_out;
    repeat (30) @(negedge clk);
    check("R4 output frozen when stopped", wave_out, v[0]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int seed;
    int hi, lo;
    seed = 32'h1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(2'd1, v); check("R1 high reg reset", v, 8'hFF);
    rd(2'd2, v); check("R1 low reg reset", v, 8'hFF);
    rd(2'd0, v); check("R1 control reset", v, 8'h00);
    check("R1 output reset", wave_out, 0);
    check("R1 irq reset", irq, 0);
    // R10 readback
    hi = $urandom_range(0, 255); lo = $urandom_range(0, 255);
    wr(2'd1, hi[7:0]); wr(2'd2, lo[7:0]);
    rd(2'd1, v); check("R10 high readback", v, hi);
    rd(2'd2, v); check("R10 low readback", v, lo);
    // R6 level control
    wr(2'd3, 8'h01); check("R6 level set high", wave_out, 1);
    rd(2'd3, v); check("R6 level readback", v[0], 1);
    wr(2'd3, 8'h00); check("R6 level set low", wave_out, 0);
    // directed corners
    run_case(0, 0, 0, 2, 1'b0, 1'b1, 1'b1);
    run_case(0, 3, 1, 0, 1'b1, 1'b1, 1'b1);
    run_case(255, 1, 3, 1, 1'b0, 1'b0, 1'b0);
    run_case(5, 0, 2, 3, 1'b1, 1'b0, 1'b1);
    // R9 set wins over a colliding clear
    wr(2'd1, 8'd0); wr(2'd2, 8'd0);
    wr(2'd0, {2'b10, 2'b00, 1'b1, 1'b1, 1'b1, 1'b1});
    wr(2'd0, {2'b10, 2'b00, 1'b1, 1'b1, 1'b1, 1'b1});
    rd(2'd0, v);
    check("R9 set beats clearing write", v[2], 1);
    check("R8 irq with set pending", irq, 1);
    wr(2'd0, {2'b10, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0});
    rd(2'd0, v);
    check("R9 write of zero keeps pending", v[2], 1);
    check("R8 irq masked by enable", irq, 0);
    wr(2'd0, 8'h04);
    rd(2'd0, v);
    check("R9 write of one clears pending", v[2], 0);
    // constrained random
    for (int k = 0; k < 24; k++) begin
      run_case($urandom_range(0, 40), $urandom_range(0, 40), $urandom_range(0, 3),
               $urandom_range(0, 3), 1'($urandom_range(0, 1)),
               1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    end
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule